// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes serial audio from four data lines. The lines share one bit clock and one word clock. It returns eight signed 32-bit channel samples, two from each line. A static format selection picks the framing, the word length and the frame length. The framing can be I2S, left-justified or right-justified. The word length can be 16, 20, 24 or 32 bits. The frame length can be 32, 48 or 64 bit clocks per word-clock period.

The serial clocks are oversampled in the system clock domain. Each line's word is rebuilt MSB first and sign-extended to 32 bits. When both halves of a frame are complete, all eight samples are presented together with a one-cycle strobe.

A legality checker rejects format combinations that the framing cannot carry. While it rejects a combination, no samples are produced. A frame-length monitor compares the measured bit clocks per word-clock period with the configured value and latches an error on any mismatch.

Top module: `saud_rx`

## Requirements
- R1: Line l (0..3) carries channel 2l+1 in the first half of the frame and channel 2l+2 in the second half. Channel c (1..8) appears on `sample_o[(c-1)*32 +: 32]`.
- R2: The first half of the frame is word clock low in I2S mode (`mode_i`=00) and word clock high in left-justified (01) and right-justified (10) modes. In I2S mode the MSB is taken on the second bit-clock rising edge after a word-clock transition. In left-justified mode it is taken on the first such edge.
- R3: In right-justified mode the LSB is the bit on the last rising edge before the next word-clock transition. Bits earlier in the half-frame than the word are ignored.
- R4: `wlen_i` selects the word length N: 00=16, 01=20, 10=24, 11=32. In I2S and left-justified modes, bits after the N-th bit of a half-frame are ignored.
- R5: Each N-bit two's-complement word is sign-extended to 32 bits, so output bits 31..N equal bit N-1.
- R6: `valid_o` is high for exactly one cycle after the second half of a frame completes, which is when the next first half begins. It is raised only when the first half of that frame also started after reset. `sample_o` changes only in a cycle with `valid_o` high.
- R7: `flen_i` selects the frame length: 00=32, 01=48, 10=64, 11 reserved. `fmt_illegal_o` is high, and `valid_o` stays low, in any of these cases:
  - `mode_i`=11 or `flen_i`=11;
  - a 32-bit word without 64-bit frames in I2S or left-justified mode;
  - right-justified mode with 20- or 32-bit words;
  - 32-bit frames with anything other than 16-bit right-justified data.
- R8: After two starts of the first half, `frame_err_o` is set if the number of bit clocks between them differs from the configured frame length. Once set, it stays set until reset.
- R9: After reset, `sample_o`, `valid_o` and `frame_err_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bck_i | input | 1 | Serial bit clock; data is sampled on its rising edge |
| wclk_i | input | 1 | Left/right word clock |
| sdata_i | input | 4 | Serial data lines, two channels each |
| mode_i | input | 2 | Framing: 00 I2S, 01 left-justified, 10 right-justified |
| wlen_i | input | 2 | Word length code |
| flen_i | input | 2 | Frame length code |
| sample_o | output | 256 | Eight sign-extended channel samples, channel 1 in the low bits |
| valid_o | output | 1 | One-cycle strobe for a new frame of samples |
| fmt_illegal_o | output | 1 | Selected format combination is not supported |
| frame_err_o | output | 1 | Sticky frame-length mismatch |

## Verification
Some properties are checked by assertions on every cycle:
- the strobe lasts a single cycle;
- the samples hold between strobes;
- no strobe appears under an illegal format;
- the frame error stays set;
- 16-bit samples are sign-extended.

Other behaviour can only be shown by the bench's scenarios, which drive whole frames in each framing and word length:
- the bit alignment of each framing;
- that filler bits are ignored;
- the channel-to-line mapping;
- the number of strobes per stream;
- that a mismatched frame length raises the error.

// File: rtl/saud_pkg.sv
package saud_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ   = 2'd2,
    FMT_RSVD = 2'd3
  } fmt_e;

  function automatic logic [6:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 7'd16;
      2'd1:    return 7'd20;
      2'd2:    return 7'd24;
      default: return 7'd32;
    endcase
  endfunction

  function automatic logic [6:0] frame_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 7'd32;
      2'd1:    return 7'd48;
      2'd2:    return 7'd64;
      default: return 7'd0;
    endcase
  endfunction
endpackage

// File: rtl/saud_sync.sv
module saud_sync #(
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             ws_i,
  input  logic [LANES-1:0] sd_i,
  output logic             tick_o,
  output logic             ws_o,
  output logic [LANES-1:0] sd_o
);
  localparam int W = LANES + 2;

  logic [W-1:0] pipe_q [STAGES];
  logic         sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
      sck_q <= 1'b0;
    end else begin
      pipe_q[0] <= {sck_i, ws_i, sd_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      sck_q <= pipe_q[STAGES-1][W-1];
    end
  end

  assign tick_o = pipe_q[STAGES-1][W-1] & ~sck_q;
  assign ws_o   = pipe_q[STAGES-1][W-2];
  assign sd_o   = pipe_q[STAGES-1][LANES-1:0];
endmodule

// File: rtl/saud_fmt_check.sv
module saud_fmt_check
  import saud_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [1:0] wlen_i,
  input  logic [1:0] flen_i,
  output logic       legal_o
);
  always_comb begin
    legal_o = 1'b1;
    if (mode_i == FMT_RSVD || flen_i == 2'd3) legal_o = 1'b0;
    // longest word needs the longest frame and left-aligned framing
    if (wlen_i == 2'd3 && (flen_i != 2'd2 || mode_i == FMT_RJ)) legal_o = 1'b0;
    if (flen_i == 2'd0 && !(mode_i == FMT_RJ && wlen_i == 2'd0)) legal_o = 1'b0;
    if (mode_i == FMT_RJ && (wlen_i == 2'd1 || wlen_i == 2'd3)) legal_o = 1'b0;
  end
endmodule

// File: rtl/saud_lane.sv
module saud_lane #(
  parameter int SAMPLE_W = 32,
  parameter int CNT_W    = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                bound_i,
  input  logic                sd_i,
  input  logic                rj_i,
  input  logic [CNT_W-1:0]    nbits_i,
  output logic [SAMPLE_W-1:0] word_o
);
  localparam int IDX_W = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] sh_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [IDX_W-1:0]    msb_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (bound_i) begin
        sh_q  <= {{(SAMPLE_W-1){1'b0}}, sd_i};
        cnt_q <= CNT_W'(1);
      end else if (rj_i || cnt_q < nbits_i) begin
        // right-justified keeps the last bits; otherwise stop after N
        sh_q <= {sh_q[SAMPLE_W-2:0], sd_i};
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign msb_idx = IDX_W'(nbits_i - 1'b1);

  always_comb begin
    for (int i = 0; i < SAMPLE_W; i++)
      word_o[i] = (CNT_W'(i) < nbits_i) ? sh_q[i] : sh_q[msb_idx];
  end
endmodule

// File: rtl/saud_frame_mon.sv
module saud_frame_mon #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             check_en_i,
  input  logic [CNT_W-1:0] exp_i,
  output logic             err_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      err_o  <= 1'b0;
    end else if (start_i) begin
      if (seen_q && check_en_i && cnt_q != exp_i) err_o <= 1'b1;
      cnt_q  <= CNT_W'(1);
      seen_q <= 1'b1;
    end else if (tick_i && cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/saud_rx.sv
module saud_rx
  import saud_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int SAMPLE_W    = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FCNT_W      = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          bck_i,
  input  logic                          wclk_i,
  input  logic [LANES-1:0]              sdata_i,
  input  logic [1:0]                    mode_i,
  input  logic [1:0]                    wlen_i,
  input  logic [1:0]                    flen_i,
  output logic [2*LANES*SAMPLE_W-1:0]   sample_o,
  output logic                          valid_o,
  output logic                          fmt_illegal_o,
  output logic                          frame_err_o
);
  localparam int NCH   = 2 * LANES;
  localparam int BIT_W = 7;

  logic             tick, ws_s, legal;
  logic [LANES-1:0] sd_s;
  logic             w1_q, w2_q, cur_ws, prv_ws, is_i2s, bound, enter_first;
  logic [BIT_W-1:0] nbits;
  logic [LANES-1:0][SAMPLE_W-1:0] word, left_q;
  logic [NCH-1:0][SAMPLE_W-1:0]   samp_q;
  logic             started_q, left_ok_q;

  saud_sync #(.LANES(LANES), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .sck_i(bck_i), .ws_i(wclk_i), .sd_i(sdata_i),
    .tick_o(tick), .ws_o(ws_s), .sd_o(sd_s)
  );

  saud_fmt_check i_fmt (.mode_i, .wlen_i, .flen_i, .legal_o(legal));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w1_q <= 1'b0;
      w2_q <= 1'b0;
    end else if (tick) begin
      w1_q <= ws_s;
      w2_q <= w1_q;
    end
  end

  // I2S: word clock delayed one bit so it aligns with the MSB
  assign is_i2s      = (mode_i == FMT_I2S);
  assign cur_ws      = is_i2s ? w1_q : ws_s;
  assign prv_ws      = is_i2s ? w2_q : w1_q;
  assign bound       = tick & (cur_ws != prv_ws);
  assign enter_first = bound & (cur_ws == ~is_i2s);
  assign nbits       = word_bits(wlen_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    saud_lane #(.SAMPLE_W(SAMPLE_W), .CNT_W(BIT_W)) i_lane (
      .clk_i, .rst_ni, .tick_i(tick), .bound_i(bound), .sd_i(sd_s[l]),
      .rj_i(mode_i == FMT_RJ), .nbits_i(nbits), .word_o(word[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q    <= '0;
      samp_q    <= '0;
      valid_o   <= 1'b0;
      started_q <= 1'b0;
      left_ok_q <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bound) begin
        started_q <= 1'b1;
        if (enter_first) begin
          if (left_ok_q && legal) begin
            for (int l = 0; l < LANES; l++) begin
              samp_q[2*l]   <= left_q[l];
              samp_q[2*l+1] <= word[l];
            end
            valid_o <= 1'b1;
          end
          left_ok_q <= 1'b0;
        end else begin
          left_q    <= word;
          left_ok_q <= started_q;
        end
      end
    end
  end

  saud_frame_mon #(.CNT_W(FCNT_W)) i_fmon (
    .clk_i, .rst_ni, .tick_i(tick), .start_i(enter_first), .check_en_i(legal),
    .exp_i(FCNT_W'(frame_bits(flen_i))), .err_o(frame_err_o)
  );

  assign sample_o      = samp_q;
  assign fmt_illegal_o = ~legal;
endmodule

// File: rtl/saud_rx_chk.sv
module saud_rx_chk #(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [1:0]                  wlen_i,
  input logic [1:0]                  flen_i,
  input logic [2*LANES*SAMPLE_W-1:0] sample_o,
  input logic                        valid_o,
  input logic                        fmt_illegal_o,
  input logic                        frame_err_o
);
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6
  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o)); // R6
  AST_NO_VALID_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_illegal_o |-> !valid_o); // R7
  AST_WORD32_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wlen_i == 2'd3 && flen_i != 2'd2) |-> fmt_illegal_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> frame_err_o); // R8

  for (genvar c = 0; c < 2*LANES; c++) begin : g_sx
    AST_SIGN_EXT16: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && wlen_i == 2'd0) |->
      ($countones(sample_o[c*SAMPLE_W+15 +: SAMPLE_W-15]) == 0 ||
       $countones(sample_o[c*SAMPLE_W+15 +: SAMPLE_W-15]) == SAMPLE_W-15)); // R5
  end
endmodule

bind saud_rx saud_rx_chk #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) i_saud_rx_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wlen_i(wlen_i), .flen_i(flen_i),
  .sample_o(sample_o), .valid_o(valid_o), .fmt_illegal_o(fmt_illegal_o),
  .frame_err_o(frame_err_o)
);

// File: tb/test_saud_rx.sv
`timescale 1ns/1ps
module test_saud_rx;
  localparam int K = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bck = 1'b0, wclk = 1'b0;
  logic [3:0]   sd = '0;
  logic [1:0]   mode = 2'd0, wlen = 2'd0, flen = 2'd2;
  logic [255:0] sample;
  logic         valid, illegal, ferr;

  int errors = 0, checks = 0;
  int valid_seen = 0;
  bit run_chk = 1'b0, exp_illegal = 1'b0, done = 1'b0;
  string cur_tag = "R9";
  logic [255:0] exp_q [$];
  bit dbuf [4][512];
  bit wbuf [513];

  always #2.5 clk = ~clk;

  saud_rx i_saud_rx (
    .clk_i(clk), .rst_ni(rst_n), .bck_i(bck), .wclk_i(wclk), .sdata_i(sd),
    .mode_i(mode), .wlen_i(wlen), .flen_i(flen), .sample_o(sample),
    .valid_o(valid), .fmt_illegal_o(illegal), .frame_err_o(ferr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit legal_fn(input logic [1:0] m, wl, fl);
    if (m == 2'd0 || m == 2'd1)
      return (fl == 2'd2) || (fl == 2'd1 && wl != 2'd3);
    if (m == 2'd2)
      return ((fl == 2'd2 || fl == 2'd1) && (wl == 2'd0 || wl == 2'd2)) ||
             (fl == 2'd0 && wl == 2'd0);
    return 1'b0;
  endfunction

  // reference: every cycle compares the legality flag and any strobe
  always @(negedge clk) begin
    if (run_chk) begin
      chk(illegal == exp_illegal, "R7", "fmt_illegal_o", 32'(illegal), 32'(exp_illegal));
      if (valid) begin
        valid_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected valid_o", 32'd1, 32'd0);
        end else begin
          logic [255:0] e;
          e = exp_q.pop_front();
          for (int c = 0; c < 8; c++)
            chk(sample[c*32 +: 32] == e[c*32 +: 32], cur_tag,
                $sformatf("ch%0d", c + 1), sample[c*32 +: 32], e[c*32 +: 32]);
        end
      end
    end
  end

  task automatic drive_bit(input bit w, input bit d0, d1, d2, d3);
    @(negedge clk);
    bck = 1'b0; wclk = w; sd = {d3, d2, d1, d0};
    repeat (4) @(negedge clk);
    bck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_scn(input logic [1:0] m, wl, fl, input int sent_len,
                         input bit exp_err, input string tag);
    int n, h, total;
    bit first, lg;
    logic [255:0] fv;
    n = (wl == 0) ? 16 : (wl == 1) ? 20 : (wl == 2) ? 24 : 32;
    h = sent_len / 2;
    total = (K + 1) * sent_len;
    first = (m != 2'd0);
    lg = legal_fn(m, wl, fl);
    run_chk = 1'b0;
    rst_n = 1'b0; bck = 1'b0; wclk = 1'b0; sd = '0;
    mode = m; wlen = wl; flen = fl;
    exp_illegal = !lg; cur_tag = tag;
    exp_q.delete(); valid_seen = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int f = 0; f <= K; f++) begin
      fv = '0;
      for (int hf = 0; hf < 2; hf++) begin
        for (int l = 0; l < 4; l++) begin
          logic [31:0] w, e;
          w = $urandom;
          for (int i = 0; i < 32; i++) e[i] = (i < n) ? w[i] : w[n-1];
          fv[(2*l + hf)*32 +: 32] = e;
          for (int k = 0; k < h; k++) begin
            int s;
            s = f*sent_len + hf*h + k;
            if (m == 2'd2)
              dbuf[l][s] = (k >= h - n) ? w[n-1-(k-(h-n))] : 1'b1;
            else
              dbuf[l][s] = (k < n) ? w[n-1-k] : 1'b1;
          end
        end
        for (int k = 0; k < h; k++)
          wbuf[f*sent_len + hf*h + k] = (hf == 0) ? first : !first;
      end
      if (f < K && lg) exp_q.push_back(fv);
    end
    wbuf[total] = first;
    run_chk = 1'b1;
    for (int i = 0; i < 4; i++)
      drive_bit((m == 2'd0 && i == 3) ? first : !first, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int s = 0; s < total; s++)
      drive_bit((m == 2'd0) ? wbuf[s+1] : wbuf[s],
                dbuf[0][s], dbuf[1][s], dbuf[2][s], dbuf[3][s]);
    repeat (20) @(negedge clk);
    run_chk = 1'b0;
    chk(valid_seen == (lg ? K : 0), lg ? "R6" : "R7", "strobe count",
        32'(valid_seen), lg ? 32'(K) : 32'd0);
    chk(exp_q.size() == 0, "R6", "pending frames", 32'(exp_q.size()), 32'd0);
    chk(ferr == exp_err, "R8", "frame_err_o", 32'(ferr), 32'(exp_err));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sample == '0, "R9", "sample_o after reset", sample[31:0], 32'd0);
    chk(valid == 1'b0, "R9", "valid_o after reset", 32'(valid), 32'd0);
    chk(ferr == 1'b0, "R9", "frame_err_o after reset", 32'(ferr), 32'd0);
    run_scn(2'd0, 2'd2, 2'd2, 64, 1'b0, "R1 R2 I2S24/64");
    run_scn(2'd1, 2'd0, 2'd1, 48, 1'b0, "R2 R4 R5 LJ16/48");
    run_scn(2'd2, 2'd2, 2'd2, 64, 1'b0, "R3 RJ24/64");
    run_scn(2'd2, 2'd0, 2'd0, 32, 1'b0, "R3 R5 RJ16/32");
    run_scn(2'd0, 2'd3, 2'd2, 64, 1'b0, "R4 I2S32/64");
    run_scn(2'd1, 2'd1, 2'd2, 64, 1'b0, "R4 R5 LJ20/64");
    run_scn(2'd0, 2'd2, 2'd1, 48, 1'b0, "R2 I2S24/48");
    run_scn(2'd1, 2'd2, 2'd0, 32, 1'b0, "R7 LJ24/32");
    run_scn(2'd0, 2'd3, 2'd1, 48, 1'b0, "R7 I2S32/48");
    run_scn(2'd2, 2'd1, 2'd2, 64, 1'b0, "R7 RJ20/64");
    run_scn(2'd1, 2'd2, 2'd2, 48, 1'b1, "R8 LJ24 cfg64 sent48");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule